// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge lets a host reach a 32-bit internal peripheral bus through three 64-bit registers: a command word, a status word and a data word. To write a peripheral, the host first loads the data word, then writes a command word whose top nibble carries a fixed key. To read, it writes only the command word. The host then polls the status word until the completion flag appears and collects the returned data and any error indication from that same word.

All fields in the 64-bit words are described in big-endian bit numbering, where bit 0 is the most significant bit (bit n maps to vector index 63-n). Write and read data of 1, 2 or 4 bytes sit left-justified in their wide fields. On the internal side they appear right-justified. The internal side is a single-outstanding request/acknowledge master with an error input.

Top module: `ireg_bridge`

## Requirements
- R1: After reset the status word reads zero, the stored command word reads zero and `bus_req` is low.
- R2: A command write launches an access only when big-endian bits 0..3 (index 63..60) equal 0xD. A command without the key starts nothing and leaves the status word unchanged.
- R3: The size field, big-endian bits 4..7 (index 59..56), accepts only 1, 2 or 4. Any other size makes the command write ignored, with no request issued and no status change.
- R4: For a write (big-endian bit 15, index 48, clear), `bus_we` is high and `bus_addr` equals command bits 32..63 (index 31..0). `bus_wdata` carries data-word index 63..56, 63..48 or 63..32 for sizes 1, 2 and 4, placed right-justified with zeros above.
- R5: `bus_req` stays high, and address, data, size and direction stay stable, until `bus_ack` is sampled high.
- R6: Status busy, big-endian bit 44 (index 19), is high from the cycle after launch until the acknowledge edge. Done, big-endian bit 52 (index 11), is set and busy cleared in the cycle after `bus_ack`. Busy and done are never both set.
- R7: For a read (bit 15 set, `bus_we` low), the low 1, 2 or 4 bytes of `bus_rdata` are returned left-justified in status big-endian bits 6..37 (index 57..26), with zeros in the unused low bits.
- R8: A `bus_err` sampled with `bus_ack` sets status big-endian bit 45 (index 18) together with done. All other error bits (big-endian 0..5, 46..51, 53..55) read zero.
- R9: A newly accepted command clears done, the error bit and the read-data field in the cycle after launch.
- R10: A command write that arrives while busy is ignored. The request in flight and the stored command word are unchanged.
- R11: Register offsets are command at 0, status at 2 and data at 3. Offset 0 reads back the last accepted command word. Offset 1 reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register offset (also selects the read mux) |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Selected register contents |
| bus_req | output | 1 | Internal bus request, held until acknowledge |
| bus_we | output | 1 | 1 = write access, 0 = read access |
| bus_addr | output | 32 | Internal bus address |
| bus_wdata | output | 32 | Right-justified write data |
| bus_size | output | 3 | Access size in bytes (1, 2 or 4) |
| bus_ack | input | 1 | Access complete |
| bus_err | input | 1 | Access failed, valid with bus_ack |
| bus_rdata | input | 32 | Right-justified read data, valid with bus_ack |

## Verification
The embedded assertions watch the handshake on every cycle. They check that a request holds its address and direction until acknowledged, that done follows an acknowledge by exactly one cycle with busy dropped, that busy and done are exclusive, that a launch clears the previous result, and that a command write during busy leaves the request alone. The bus-side lane placement, the left-justified read field, the exact status word for each size and direction, and the rejection of unkeyed or oddly sized commands depend on concrete data values. Only the bench's vectors and directed cases can show those.

// File: rtl/ireg_bridge_pkg.sv
// Shared constants and types for the indirect register bridge.
// Assumes a 64-bit host word described in big-endian bit numbering;
// every index below is converted to little-endian vector position.
package ireg_bridge_pkg;
    localparam int HOST_W = 64;
    localparam int BUS_AW = 32;
    localparam int BUS_DW = 32;
    localparam int SZ_W   = 3;

    localparam int CTL_KEY_MSB  = HOST_W - 1 - 0;
    localparam int CTL_KEY_LSB  = HOST_W - 1 - 3;
    localparam int CTL_SIZE_MSB = HOST_W - 1 - 4;
    localparam int CTL_SIZE_LSB = HOST_W - 1 - 7;
    localparam int CTL_RD_BIT   = HOST_W - 1 - 15;
    localparam int CTL_ADDR_MSB = HOST_W - 1 - 32;

    localparam int STS_RD_MSB   = HOST_W - 1 - 6;
    localparam int STS_RD_LSB   = HOST_W - 1 - 37;
    localparam int STS_BUSY     = HOST_W - 1 - 44;
    localparam int STS_BUSERR   = HOST_W - 1 - 45;
    localparam int STS_DONE     = HOST_W - 1 - 52;

    localparam logic [3:0] LAUNCH_KEY = 4'hD;

    localparam logic [1:0] OFF_CMD  = 2'd0;
    localparam logic [1:0] OFF_STAT = 2'd2;
    localparam logic [1:0] OFF_DATA = 2'd3;

    typedef struct packed {
        logic              legal;
        logic              rd;
        logic [SZ_W-1:0]   nbytes;
        logic [BUS_AW-1:0] addr;
    } cmd_t;
endpackage

// File: rtl/ireg_cmd_decode.sv
// Splits a command word into its fields and judges whether it may launch.
// Assumes nothing about timing: purely combinational.
module ireg_cmd_decode
    import ireg_bridge_pkg::*;
(
    input  logic [HOST_W-1:0] cmd_word,
    output cmd_t              cmd
);
    logic [3:0] key_f;
    logic [3:0] size_f;

    // Field extraction and legality test
    always_comb begin
        key_f      = cmd_word[CTL_KEY_MSB:CTL_KEY_LSB];
        size_f     = cmd_word[CTL_SIZE_MSB:CTL_SIZE_LSB];
        cmd.rd     = cmd_word[CTL_RD_BIT];
        cmd.addr   = cmd_word[CTL_ADDR_MSB:0];
        cmd.nbytes = size_f[SZ_W-1:0];
        cmd.legal  = (key_f == LAUNCH_KEY) &&
                     (size_f == 4'd1 || size_f == 4'd2 || size_f == 4'd4);
    end
endmodule

// File: rtl/ireg_lane_align.sv
// Moves data between left-justified host fields and right-justified bus lanes.
// Assumes sizes of 1, 2 or 4 bytes; the shift leaves unused bits zero.
module ireg_lane_align
    import ireg_bridge_pkg::*;
(
    input  logic [HOST_W-1:0] data_word,
    input  logic [SZ_W-1:0]   wr_nbytes,
    input  logic [BUS_DW-1:0] bus_rdata,
    input  logic [SZ_W-1:0]   rd_nbytes,
    output logic [BUS_DW-1:0] wr_lane,
    output logic [BUS_DW-1:0] rd_field
);
    localparam int BYTES = BUS_DW / 8;
    logic [5:0] wr_sh;
    logic [5:0] rd_sh;

    // Write: top bytes of the data word slide down to the bus LSBs
    always_comb begin
        wr_sh   = 6'(8 * (BYTES - int'(wr_nbytes)));
        wr_lane = data_word[HOST_W-1 -: BUS_DW] >> wr_sh;
    end

    // Read: low bus bytes slide up to the top of the status field
    always_comb begin
        rd_sh    = 6'(8 * (BYTES - int'(rd_nbytes)));
        rd_field = bus_rdata << rd_sh;
    end
endmodule

// File: rtl/ireg_bus_seq.sv
// Single-outstanding request sequencer toward the internal bus.
// Assumes launch is only pulsed while idle; holds the request until ack
// and records done, error and read data at the acknowledge edge.
module ireg_bus_seq
    import ireg_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  cmd_t              cmd,
    input  logic [BUS_DW-1:0] wr_lane,
    input  logic [BUS_DW-1:0] rd_field_in,
    input  logic              bus_ack,
    input  logic              bus_err,
    output logic              bus_req,
    output logic              bus_we,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [BUS_DW-1:0] bus_wdata,
    output logic [SZ_W-1:0]   bus_size,
    output logic              done,
    output logic              err,
    output logic [BUS_DW-1:0] rd_field
);
    // Request, completion and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            bus_size  <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
            rd_field  <= '0;
        end else if (launch) begin
            bus_req   <= 1'b1;
            bus_we    <= !cmd.rd;
            bus_addr  <= cmd.addr;
            bus_wdata <= cmd.rd ? '0 : wr_lane;
            bus_size  <= cmd.nbytes;
            done      <= 1'b0;
            err       <= 1'b0;
            rd_field  <= '0;
        end else if (bus_req && bus_ack) begin
            bus_req   <= 1'b0;
            done      <= 1'b1;
            err       <= bus_err;
            rd_field  <= bus_we ? '0 : rd_field_in;
        end
    end

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) &&
                                   $stable(bus_we) && $stable(bus_wdata) && $stable(bus_size)));

    assert_done_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> (done && !bus_req));

    assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && done));

    assert_launch_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (bus_req && !done && !err && rd_field == '0));
endmodule

// File: rtl/ireg_bridge.sv
// Indirect register bridge top: host register file, launch gate and status
// assembly around the bus sequencer. Assumes host reads are combinational on
// host_addr and that one access is in flight at most.
module ireg_bridge
    import ireg_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [63:0]       host_wdata,
    output logic [63:0]       host_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [31:0]       bus_addr,
    output logic [31:0]       bus_wdata,
    output logic [2:0]        bus_size,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [31:0]       bus_rdata
);
    cmd_t              cmd;
    logic [HOST_W-1:0] cmd_q;
    logic [HOST_W-1:0] data_q;
    logic [HOST_W-1:0] status;
    logic [BUS_DW-1:0] wr_lane;
    logic [BUS_DW-1:0] rd_align;
    logic [BUS_DW-1:0] rd_field;
    logic              done;
    logic              err;
    logic              cmd_wr;
    logic              launch;

    ireg_cmd_decode u_dec (
        .cmd_word (host_wdata),
        .cmd      (cmd)
    );

    ireg_lane_align u_align (
        .data_word (data_q),
        .wr_nbytes (cmd.nbytes),
        .bus_rdata (bus_rdata),
        .rd_nbytes (bus_size),
        .wr_lane   (wr_lane),
        .rd_field  (rd_align)
    );

    // Launch gate: keyed, legal size, idle
    always_comb begin
        cmd_wr = host_we && (host_addr == OFF_CMD);
        launch = cmd_wr && cmd.legal && !bus_req;
    end

    ireg_bus_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .cmd         (cmd),
        .wr_lane     (wr_lane),
        .rd_field_in (rd_align),
        .bus_ack     (bus_ack),
        .bus_err     (bus_err),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_size    (bus_size),
        .done        (done),
        .err         (err),
        .rd_field    (rd_field)
    );

    // Host-writable registers: accepted command and data word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            data_q <= '0;
        end else begin
            if (launch)
                cmd_q <= host_wdata;
            if (host_we && host_addr == OFF_DATA)
                data_q <= host_wdata;
        end
    end

    // Status word assembly
    always_comb begin
        status                        = '0;
        status[STS_BUSY]              = bus_req;
        status[STS_DONE]              = done;
        status[STS_BUSERR]            = err;
        status[STS_RD_MSB:STS_RD_LSB] = rd_field;
    end

    // Host read mux
    always_comb begin
        unique case (host_addr)
            OFF_CMD:  host_rdata = cmd_q;
            OFF_STAT: host_rdata = status;
            OFF_DATA: host_rdata = data_q;
            default:  host_rdata = '0;
        endcase
    end

    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_req) |=> ($stable(bus_addr) && $stable(bus_we) && $stable(cmd_q)));

    assert_no_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !bus_req && host_wdata[CTL_KEY_MSB:CTL_KEY_LSB] != LAUNCH_KEY)
            |=> (!bus_req && $stable(status)));
endmodule

// File: tb/ireg_bridge_bench.sv
module ireg_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [2:0]  bus_size;
    logic        bus_ack = 1'b0;
    logic        bus_err = 1'b0;
    logic [31:0] bus_rdata = '0;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    ireg_bridge u_ireg_bridge (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_size(bus_size), .bus_ack(bus_ack), .bus_err(bus_err),
        .bus_rdata(bus_rdata)
    );

    typedef struct packed {
        logic [63:0] cmd;
        logic [63:0] data;
        logic [31:0] rdata;
        logic        err;
        logic [31:0] exp_wdata;
        logic [31:0] exp_field;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{64'hD100_0100_0000_1234, 64'hAB00_0000_0000_0000, 32'h0, 1'b0, 32'h0000_00AB, 32'h0},
        '{64'hD200_0100_0000_2000, 64'hBEEF_0000_0000_0000, 32'h0, 1'b0, 32'h0000_BEEF, 32'h0},
        '{64'hD400_0100_0000_3000, 64'h1234_5678_9ABC_DEF0, 32'h0, 1'b0, 32'h1234_5678, 32'h0},
        '{64'hD101_0100_0000_0040, 64'h0, 32'hFFFF_FFC3, 1'b0, 32'h0, 32'hC300_0000},
        '{64'hD201_0100_0000_0050, 64'h0, 32'hFFFF_A55A, 1'b0, 32'h0, 32'hA55A_0000},
        '{64'hD401_0100_0000_0060, 64'h0, 32'hCAFE_F00D, 1'b1, 32'h0, 32'hCAFE_F00D},
        '{64'hD400_0100_0000_0070, 64'h5555_AAAA_0000_0000, 32'h0, 1'b1, 32'h5555_AAAA, 32'h0}
    };

    function automatic logic [63:0] mkstat(logic busy, logic done, logic err, logic [31:0] fld);
        logic [63:0] s;
        s = '0;
        s[19] = busy;
        s[11] = done;
        s[18] = err;
        s[57:26] = fld;
        return s;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(logic [1:0] a, logic [63:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic read_reg(logic [1:0] a, output logic [63:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic respond(logic [31:0] rd, logic e);
        bus_ack = 1'b1; bus_rdata = rd; bus_err = e;
        @(negedge clk);
        bus_ack = 1'b0; bus_err = 1'b0; bus_rdata = '0;
    endtask

    initial begin
        logic [63:0] r;
        repeat (3) @(negedge clk);
        // R1: reset state
        read_reg(2'd2, r); check("R1 status", r, 64'h0);
        read_reg(2'd0, r); check("R1 cmd", r, 64'h0);
        check("R1 req", {63'h0, bus_req}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R4 writes, R7 reads, R6 busy/done, R8 errors
        for (int i = 0; i < NV; i++) begin
            logic rd;
            rd = VEC[i].cmd[48];
            if (!rd) host_write(2'd3, VEC[i].data);
            host_write(2'd0, VEC[i].cmd);
            check("R6 req up", {63'h0, bus_req}, 64'h1);
            check("R4 addr", {32'h0, bus_addr}, {32'h0, VEC[i].cmd[31:0]});
            check("R4 we", {63'h0, bus_we}, {63'h0, !rd});
            if (!rd) check("R4 wdata", {32'h0, bus_wdata}, {32'h0, VEC[i].exp_wdata});
            read_reg(2'd2, r); check("R6 busy", r, mkstat(1'b1, 1'b0, 1'b0, 32'h0));
            respond(VEC[i].rdata, VEC[i].err);
            read_reg(2'd2, r);
            check(rd ? "R7 result" : "R8 result", r, mkstat(1'b0, 1'b1, VEC[i].err, VEC[i].exp_field));
            read_reg(2'd0, r); check("R11 cmd readback", r, VEC[i].cmd);
        end

        // R2: no key, status unchanged (still done + error from last vector)
        host_write(2'd0, 64'hC100_0100_0000_0080);
        check("R2 no req", {63'h0, bus_req}, 64'h0);
        read_reg(2'd2, r); check("R2 status kept", r, mkstat(1'b0, 1'b1, 1'b1, 32'h0));
        // R3: illegal sizes 3 and 0
        host_write(2'd0, 64'hD300_0100_0000_0080);
        check("R3 size3 no req", {63'h0, bus_req}, 64'h0);
        host_write(2'd0, 64'hD000_0100_0000_0080);
        check("R3 size0 no req", {63'h0, bus_req}, 64'h0);
        read_reg(2'd2, r); check("R3 status kept", r, mkstat(1'b0, 1'b1, 1'b1, 32'h0));
        read_reg(2'd0, r); check("R3 cmd kept", r, VEC[NV-1].cmd);

        // R9: new legal launch clears done and error
        host_write(2'd0, 64'hD401_0100_0000_0090);
        read_reg(2'd2, r); check("R9 cleared", r, mkstat(1'b1, 1'b0, 1'b0, 32'h0));
        // R10: command during busy ignored
        host_write(2'd0, 64'hD100_0100_0000_0099);
        check("R10 addr kept", {32'h0, bus_addr}, 64'h90);
        check("R10 we kept", {63'h0, bus_we}, 64'h0);
        read_reg(2'd0, r); check("R10 cmd kept", r, 64'hD401_0100_0000_0090);
        // R5: request held while ack is late
        repeat (3) @(negedge clk);
        check("R5 req held", {63'h0, bus_req}, 64'h1);
        check("R5 addr held", {32'h0, bus_addr}, 64'h90);
        respond(32'h0BAD_CAFE, 1'b0);
        read_reg(2'd2, r); check("R7 late result", r, mkstat(1'b0, 1'b1, 1'b0, 32'h0BAD_CAFE));

        // R11: offset 1 reads zero, writes to it touch nothing
        host_write(2'd3, 64'h0123_4567_89AB_CDEF);
        host_write(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        read_reg(2'd1, r); check("R11 offset1 zero", r, 64'h0);
        read_reg(2'd3, r); check("R11 data kept", r, 64'h0123_4567_89AB_CDEF);
        check("R11 no req", {63'h0, bus_req}, 64'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule